// File: doc/BRIEF.md
# Sequential Restoring Integer Divider

This block divides one integer by another over several clock cycles and returns both the quotient and the remainder. A single-cycle `start` pulse captures the dividend, the divisor and a mode select that picks signed or unsigned arithmetic. The block then works out one quotient bit per clock by shift-and-subtract, with a restore when a trial subtraction goes below zero. When it finishes, it raises `done` for exactly one cycle.

The working state is one double-width register. Its upper half holds the partial remainder and its lower half holds the dividend as it shifts out, with the quotient bits filling in behind it. The dividend is shifted once before the first trial subtraction. After the last iteration the upper half is shifted right by one bit to give the true remainder.

In signed mode the block divides the magnitudes and then fixes the signs of the results. It does not detect a zero divisor or signed overflow; it just produces well-defined bit patterns in both cases.

Top module: `seq_divider`

## Requirements
- R1: After reset, `busy` and `done` are 0 and both `quotient` and `remainder` read 0.
- R2: In unsigned mode (`signedMode`=0) with a nonzero divisor, `quotient` is floor(dividend/divisor) and `remainder` is dividend − quotient·divisor. Both operands are read as unsigned WIDTH-bit numbers.
- R3: In signed mode (`signedMode`=1), operands are two's complement. The quotient truncates toward zero, the remainder takes the sign of the dividend, and dividend = quotient·divisor + remainder holds. Examples: −7/2 gives −3 remainder −1, and −7/−2 gives 3 remainder −1.
- R4: `start` is sampled at a rising clock edge while `busy` is 0. `busy` is 1 from the next edge onward. `done` rises at the (WIDTH+1)-th edge after the sampling edge, and `busy` is 0 from that same edge.
- R5: `done` is high for exactly one cycle. `quotient` and `remainder` keep their values until the next operation completes.
- R6: A `start` pulse while `busy` is 1 is ignored. The running operation finishes with its original operands and its original timing.
- R7: In unsigned mode a zero divisor still completes normally, with an all-ones `quotient` and `remainder` equal to the dividend.
- R8: Unsigned divisors with the top bit set give correct results, including divisors larger than the dividend.
- R9: In signed mode the most negative dividend is handled. Dividing it by −1 gives a quotient equal to the most negative value (wrapped) and a remainder of 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rstN | input | 1 | Active-low asynchronous reset |
| start | input | 1 | One-cycle request to begin a division |
| signedMode | input | 1 | 1 = two's complement operands, 0 = unsigned |
| dividend | input | WIDTH | Number to be divided |
| divisor | input | WIDTH | Number to divide by |
| busy | output | 1 | An operation is in progress |
| done | output | 1 | One-cycle pulse when results are valid |
| quotient | output | WIDTH | Quotient of the last finished operation |
| remainder | output | WIDTH | Remainder of the last finished operation |

## Verification
The remainder-bound assertions assume a nonzero divisor magnitude and are gated off when the divisor is zero. Zero divisors are therefore covered only by directed vectors that compare exact bit patterns. The random signed pairs leave out the most-negative-by-minus-one case, because the bench's own reference arithmetic is not defined there; that pair is covered by a fixed vector. The handshake assertions assume `start` matters only while the block is idle, and the bench deliberately pulses it during a run to exercise that assumption.

// File: rtl/div_pkg.sv
package div_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_FIX  = 2'd2
  } divState_t;

  typedef struct packed {
    logic load;     // capture operands, pre-shift
    logic iterate;  // one trial subtract and shift
    logic fix;      // final right shift and sign correction
  } divStrobes_t;
endpackage

// File: rtl/div_ctrl.sv
module div_ctrl
  import div_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        start,
  output divStrobes_t strobes,
  output logic        busy,
  output logic        done
);
  localparam int CW = $clog2(WIDTH + 1);
  localparam logic [CW-1:0] LAST = CW'(WIDTH - 1);

  divState_t state;
  logic [CW-1:0] iterCnt;
  logic doneReg;

  always_comb begin
    strobes.load    = (state == ST_IDLE) && start;
    strobes.iterate = (state == ST_RUN);
    strobes.fix     = (state == ST_FIX);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      iterCnt <= '0;
      doneReg <= 1'b0;
    end else begin
      doneReg <= 1'b0;
      case (state)
        ST_IDLE: if (start) begin
          state   <= ST_RUN;
          iterCnt <= '0;
        end
        ST_RUN: begin
          iterCnt <= iterCnt + 1'b1;
          if (iterCnt == LAST) state <= ST_FIX;
        end
        ST_FIX: begin
          state   <= ST_IDLE;
          doneReg <= 1'b1;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign busy = (state != ST_IDLE);
  assign done = doneReg;

  // R5
  done_single_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  // R4
  done_not_busy_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !busy);

  // R4
  start_to_busy_chk: assert property (@(posedge clk) disable iff (!rstN)
    (start && !busy) |=> busy);

  // R6
  run_no_reload_chk: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> !strobes.load);
endmodule

// File: rtl/div_datapath.sv
module div_datapath
  import div_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic             clk,
  input  logic             rstN,
  input  divStrobes_t      strobes,
  input  logic             signedMode,
  input  logic [WIDTH-1:0] dividend,
  input  logic [WIDTH-1:0] divisor,
  output logic [WIDTH-1:0] quotient,
  output logic [WIDTH-1:0] remainder
);
  localparam int XW = WIDTH + 1;

  logic [WIDTH-1:0] remHi, remLo, divMag;
  logic             extBit;
  logic             negQuot, negRem;

  logic             aNeg, bNeg;
  logic [WIDTH-1:0] aMag, bMag;
  logic [XW-1:0]    wideHi, trialDiff;
  logic             fits;
  logic [WIDTH-1:0] nextHi, remMag;

  always_comb begin
    aNeg      = signedMode && dividend[WIDTH-1];
    bNeg      = signedMode && divisor[WIDTH-1];
    aMag      = aNeg ? (~dividend + 1'b1) : dividend;
    bMag      = bNeg ? (~divisor + 1'b1) : divisor;
    wideHi    = {extBit, remHi};
    trialDiff = wideHi - {1'b0, divMag};
    fits      = !trialDiff[XW-1] || extBit;
    nextHi    = fits ? trialDiff[WIDTH-1:0] : remHi;
    remMag    = {extBit, remHi[WIDTH-1:1]};
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      remHi     <= '0;
      remLo     <= '0;
      extBit    <= 1'b0;
      divMag    <= '0;
      negQuot   <= 1'b0;
      negRem    <= 1'b0;
      quotient  <= '0;
      remainder <= '0;
    end else if (strobes.load) begin
      remHi   <= {{(WIDTH-1){1'b0}}, aMag[WIDTH-1]};
      remLo   <= {aMag[WIDTH-2:0], 1'b0};
      extBit  <= 1'b0;
      divMag  <= bMag;
      negQuot <= aNeg ^ bNeg;
      negRem  <= aNeg;
    end else if (strobes.iterate) begin
      extBit <= nextHi[WIDTH-1];
      remHi  <= {nextHi[WIDTH-2:0], remLo[WIDTH-1]};
      remLo  <= {remLo[WIDTH-2:0], fits};
    end else if (strobes.fix) begin
      quotient  <= negQuot ? (~remLo + 1'b1) : remLo;
      remainder <= negRem ? (~remMag + 1'b1) : remMag;
    end
  end

  // R8
  partial_bound_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.iterate && divMag != '0) |->
      ({1'b0, wideHi} < {divMag, 1'b0}));

  // R2
  final_rem_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.fix && divMag != '0) |-> (remMag < divMag));
endmodule

// File: rtl/seq_divider.sv
module seq_divider #(
  parameter int WIDTH = 32
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             start,
  input  logic             signedMode,
  input  logic [WIDTH-1:0] dividend,
  input  logic [WIDTH-1:0] divisor,
  output logic             busy,
  output logic             done,
  output logic [WIDTH-1:0] quotient,
  output logic [WIDTH-1:0] remainder
);
  div_pkg::divStrobes_t strobes;

  div_ctrl #(.WIDTH(WIDTH)) u_ctrl (
    .clk(clk), .rstN(rstN), .start(start),
    .strobes(strobes), .busy(busy), .done(done)
  );

  div_datapath #(.WIDTH(WIDTH)) u_dp (
    .clk(clk), .rstN(rstN), .strobes(strobes),
    .signedMode(signedMode), .dividend(dividend), .divisor(divisor),
    .quotient(quotient), .remainder(remainder)
  );
endmodule

// File: tb/sim_seq_divider.sv
module sim_seq_divider;
  localparam int W = 32;
  localparam int NV = 11;
  // {signedMode, dividend, divisor, quotient, remainder}
  localparam logic [4*W:0] VEC [NV] = '{
    {1'b0, 32'd7,        32'd2,        32'd3,        32'd1},        // R2
    {1'b0, 32'd100,      32'd7,        32'd14,       32'd2},        // R2
    {1'b0, 32'hFFFFFFFF, 32'd1,        32'hFFFFFFFF, 32'd0},        // R2
    {1'b0, 32'd3,        32'd9,        32'd0,        32'd3},        // R2
    {1'b0, 32'hFFFFFFFF, 32'h80000000, 32'd1,        32'h7FFFFFFF}, // R8
    {1'b0, 32'h80000000, 32'hFFFFFFFF, 32'd0,        32'h80000000}, // R8
    {1'b1, 32'hFFFFFFF9, 32'd2,        32'hFFFFFFFD, 32'hFFFFFFFF}, // R3
    {1'b1, 32'hFFFFFFF9, 32'hFFFFFFFE, 32'd3,        32'hFFFFFFFF}, // R3
    {1'b1, 32'd7,        32'hFFFFFFFE, 32'hFFFFFFFD, 32'd1},        // R3
    {1'b1, 32'h80000000, 32'hFFFFFFFF, 32'h80000000, 32'd0},        // R9
    {1'b0, 32'd5,        32'd0,        32'hFFFFFFFF, 32'd5}         // R7
  };

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic start = 1'b0;
  logic signedMode = 1'b0;
  logic [W-1:0] dividend = '0, divisor = '0;
  logic busy, done;
  logic [W-1:0] quotient, remainder;
  int checks = 0, fails = 0;
  int lat;

  always #2.5 clk = ~clk;

  seq_divider #(.WIDTH(W)) u0 (
    .clk(clk), .rstN(rstN), .start(start), .signedMode(signedMode),
    .dividend(dividend), .divisor(divisor), .busy(busy), .done(done),
    .quotient(quotient), .remainder(remainder)
  );

  task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // drives one operation; lat = negedges from launch until done seen
  task automatic runDiv(input logic s, input logic [W-1:0] a, input logic [W-1:0] b,
                        input bool_dummy_unused = 1'b0);
    @(negedge clk);
    signedMode = s; dividend = a; divisor = b; start = 1'b1;
    lat = 0;
    do begin
      @(negedge clk);
      start = 1'b0;
      lat++;
    end while (!done && lat < W + 20);
  endtask

  initial begin
    #100000;
    fails++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    // R1 reset state
    #1;
    check("R1 busy", {31'd0, busy}, 32'd0);
    check("R1 done", {31'd0, done}, 32'd0);
    check("R1 quotient", quotient, 32'd0);
    check("R1 remainder", remainder, 32'd0);
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    for (int i = 0; i < NV; i++) begin
      runDiv(VEC[i][4*W], VEC[i][4*W-1:3*W], VEC[i][3*W-1:2*W]);
      check($sformatf("R2/R3/R7/R8/R9 vec%0d quotient", i), quotient, VEC[i][2*W-1:W]);
      check($sformatf("R2/R3/R7/R8/R9 vec%0d remainder", i), remainder, VEC[i][W-1:0]);
      check("R4 latency", lat, W + 2);
    end

    // R5: done lasts one cycle, results hold
    begin
      logic [W-1:0] q0, r0;
      q0 = quotient; r0 = remainder;
      @(negedge clk);
      check("R5 done low", {31'd0, done}, 32'd0);
      repeat (4) @(negedge clk);
      check("R5 quotient hold", quotient, q0);
      check("R5 remainder hold", remainder, r0);
    end

    // R4 busy during the run; R6 start while busy ignored
    @(negedge clk);
    signedMode = 1'b0; dividend = 32'd1000; divisor = 32'd33; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check("R4 busy", {31'd0, busy}, 32'd1);
    repeat (5) @(negedge clk);
    dividend = 32'd9; divisor = 32'd4; signedMode = 1'b1; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    lat = 7;
    while (!done && lat < W + 20) begin
      @(negedge clk);
      lat++;
    end
    check("R6 latency", lat, W + 2);
    check("R6 quotient", quotient, 32'd30);
    check("R6 remainder", remainder, 32'd10);
    @(negedge clk);
    check("R6 idle after", {31'd0, busy}, 32'd0);

    // R2 / R3 random pairs against the division identity
    for (int k = 0; k < 300; k++) begin
      logic [W-1:0] a, b;
      logic s;
      a = $urandom; b = $urandom >> ($urandom % 32);
      if (b == 0) b = 32'd3;
      s = k[0];
      if (s && a == 32'h80000000 && b == 32'hFFFFFFFF) b = 32'd5;
      runDiv(s, a, b);
      if (s) begin
        check("R3 rand quotient", quotient, 32'($signed(a) / $signed(b)));
        check("R3 rand remainder", remainder, 32'($signed(a) % $signed(b)));
      end else begin
        check("R2 rand quotient", quotient, a / b);
        check("R2 rand remainder", remainder, a % b);
      end
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule